// File: doc/BRIEF.md
# Clocked Serial Shift Port

A byte-wide synchronous serial transceiver meant to sit beside a small processor core. Software fills an eight-bit shift register through two four-bit registers and sets a start bit. The block then shifts the byte out on a data line, least significant bit first. At the same time it shifts the receive line into the same register, so the received byte reads back through the same two nibble registers once the transfer ends.

As master, the block divides the system clock to make the shift clock and drives it out. As slave, it follows a clock that arrives on a pin, through a synchronizer. In slave mode a ready line tells the remote master that a transfer is armed. The clock polarity is fixed by a parameter. It sets the idle level of the clock and the edge that launches each output bit. A separate register bit picks whether received data is taken on that launch edge or on the opposite edge. Each completed byte raises a sticky flag, and an enable bit decides whether the flag reaches the interrupt line.

Top module: `sio_shift_port`

## Requirements
- R1: After reset all four registers read 0, the interrupt and ready outputs are 0, and the clock output sits at its idle level (1 with the default negative polarity).
- R2: While idle, a write to address 0 loads byte bits 3:0 and a write to address 1 loads bits 7:4. Reads of those addresses return the same bits.
- R3: Writing 1 to bit 0 of address 2 while idle starts a transfer, and bit 0 of address 2 reads 1 while it runs. It ends after exactly 8 shift-clock cycles, when bit 0 of address 3 (done flag) becomes 1 and bit 0 of address 2 returns to 0.
- R4: Serial output goes least significant bit first and changes on the launch edge, which is the falling edge for negative polarity. Each bit is stable at the following trailing edge.
- R5: Received bits fill the register from bit 0 to bit 7 and read back through addresses 0 and 1 after the transfer.
- R6: With bit 2 of address 2 at 1, the receive line is sampled on the launch edge. With it at 0, the receive line is sampled on the trailing edge.
- R7: With bit 1 of address 2 at 1 (master), the clock output is enabled, each clock half-period lasts CLK_DIV/2 system clocks, and the clock returns to the idle level after the transfer.
- R8: With bit 1 of address 2 at 0 (slave), shifting follows edges of the clock input. The ready output rises when the transfer starts and falls after the first launch edge.
- R9: The done flag is set at every transfer end whatever bit 1 of address 3 (interrupt enable) holds. The interrupt output is 1 only while both are 1.
- R10: Writing 1 to bit 0 of address 3 clears the done flag. Writing 0 there leaves it set.
- R11: A write to address 2 during a transfer has no effect: the transfer still ends after 8 cycles and no further clock edges follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 4 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 4 | Register read data (combinational) |
| sclk_i | input | 1 | Shift clock input in slave mode |
| sclk_o | output | 1 | Shift clock output in master mode |
| sclk_oe_o | output | 1 | Clock pin output enable (master mode) |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data |
| ready_o | output | 1 | Slave armed indication to the remote master |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
Transfers run in both master and slave mode with distinct transmit and receive bytes, including alternating and near-constant patterns, so a bit-order or nibble swap shows up. The remote side changes the receive line to the inverse of the current bit between the launch and the trailing edge. As a result, the byte read back is the sent pattern or its complement depending on the edge-select bit, and a design sampling on the wrong edge shows up at once. The interrupt enable is toggled around a completed flag, and a start write is issued mid-transfer. Together these show that the flag ignores the enable, that a stray start neither restarts nor lengthens the transfer, and that the clock stops at the idle level.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } sio_reg_e;

  typedef struct packed {
    logic lead;   // edge leaving the idle level: launches data
    logic trail;  // edge returning to idle: ends a clock cycle
  } sio_edge_t;
endpackage

// File: rtl/sio_clk_gen.sv
module sio_clk_gen
  import sio_pkg::*;
#(
  parameter int   CLK_DIV  = 4,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  output sio_edge_t edge_o,
  output logic      sclk_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign edge_o.lead  = tick && !phase_q;
  assign edge_o.trail = tick &&  phase_q;
  assign sclk_o       = phase_q ? ~IDLE_LVL : IDLE_LVL;

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sclk_o == IDLE_LVL)) else $error("idle level"); // R7
endmodule

// File: rtl/sio_edge_det.sv
module sio_edge_det
  import sio_pkg::*;
#(
  parameter logic NEG_POL = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      pin_i,
  output sio_edge_t edge_o
);
  localparam logic IDLE_LVL = NEG_POL;

  logic [1:0] sync_q;
  logic       prev_q;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{IDLE_LVL}};
      prev_q <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise = sync_q[1] && !prev_q;
  assign fall = !sync_q[1] && prev_q;

  generate
    if (NEG_POL) begin : g_neg
      assign edge_o.lead  = en_i && fall;
      assign edge_o.trail = en_i && rise;
    end else begin : g_pos
      assign edge_o.lead  = en_i && rise;
      assign edge_o.trail = en_i && fall;
    end
  endgenerate

  AST_EDGE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o.lead |=> !edge_o.lead) else $error("edge spacing"); // R8
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              start_i,
  input  logic              lead_samp_i,
  input  sio_edge_t         edge_i,
  input  logic              sdi_i,
  output logic [2*NIB_W-1:0] data_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int DATA_W = 2 * NIB_W;
  localparam int BW     = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sreg_q;
  logic [BW-1:0]     bit_q;
  logic              sdo_q;
  logic              shift_now;

  assign shift_now = lead_samp_i ? edge_i.lead : edge_i.trail;
  assign done_o    = edge_i.trail && (bit_q == BW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else if (shift_now) begin
      sreg_q <= {sdi_i, sreg_q[DATA_W-1:1]};
    end else begin
      if (load_lo_i) sreg_q[NIB_W-1:0]      <= nib_i;
      if (load_hi_i) sreg_q[DATA_W-1:NIB_W] <= nib_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sdo_q <= 1'b0;
    else if (edge_i.lead) sdo_q <= sreg_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           bit_q <= '0;
    else if (start_i)      bit_q <= '0;
    else if (edge_i.trail) bit_q <= bit_q + 1'b1;
  end

  assign data_o = sreg_q;
  assign sdo_o  = sdo_q;

  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BW'(DATA_W)) else $error("bit counter range"); // R3
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
  import sio_pkg::*;
#(
  parameter int   NIB_W   = 4,
  parameter int   CLK_DIV = 4,
  parameter logic NEG_POL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [3:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [3:0] rd_data_o,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       sclk_oe_o,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       ready_o,
  output logic       irq_o
);
  localparam int   DATA_W   = 2 * NIB_W;
  localparam logic IDLE_LVL = NEG_POL;

  logic busy_q, master_q, lead_samp_q, flag_q, irq_en_q, ready_q;
  logic wr_lo, wr_hi, wr_ctrl, wr_stat, start;
  logic done;
  logic [DATA_W-1:0] data;
  sio_edge_t gen_edge, pin_edge, act_edge;

  assign wr_lo   = wr_en_i && (wr_addr_i == REG_LO)   && !busy_q;
  assign wr_hi   = wr_en_i && (wr_addr_i == REG_HI)   && !busy_q;
  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_stat = wr_en_i && (wr_addr_i == REG_STAT);
  assign start   = wr_ctrl && !busy_q && wr_data_i[0];

  sio_clk_gen #(.CLK_DIV(CLK_DIV), .IDLE_LVL(IDLE_LVL)) u_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q && master_q),
    .edge_o (gen_edge),
    .sclk_o (sclk_o)
  );

  sio_edge_det #(.NEG_POL(NEG_POL)) u_edge_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q && !master_q),
    .pin_i  (sclk_i),
    .edge_o (pin_edge)
  );

  assign act_edge = master_q ? gen_edge : pin_edge;

  sio_shifter #(.NIB_W(NIB_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_lo_i   (wr_lo),
    .load_hi_i   (wr_hi),
    .nib_i       (wr_data_i[NIB_W-1:0]),
    .start_i     (start),
    .lead_samp_i (lead_samp_q),
    .edge_i      (act_edge),
    .sdi_i       (sdi_i),
    .data_o      (data),
    .sdo_o       (sdo_o),
    .done_o      (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      master_q    <= 1'b0;
      lead_samp_q <= 1'b0;
    end else if (wr_ctrl && !busy_q) begin
      busy_q      <= wr_data_i[0];
      master_q    <= wr_data_i[1];
      lead_samp_q <= wr_data_i[2];
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (done)                      flag_q <= 1'b1;
      else if (wr_stat && wr_data_i[0]) flag_q <= 1'b0;
      if (wr_stat) irq_en_q <= wr_data_i[1];
    end
  end

  // slave handshake: armed from start until the first launch edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ready_q <= 1'b0;
    else if (start)                         ready_q <= !wr_data_i[1];
    else if (act_edge.lead || !busy_q)      ready_q <= 1'b0;
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_LO:   rd_data_o = data[NIB_W-1:0];
      REG_HI:   rd_data_o = data[DATA_W-1:NIB_W];
      REG_CTRL: rd_data_o = {1'b0, lead_samp_q, master_q, busy_q};
      default:  rd_data_o = {2'b00, irq_en_q, flag_q};
    endcase
  end

  assign ready_o   = ready_q;
  assign irq_o     = flag_q && irq_en_q;
  assign sclk_oe_o = master_q;

  AST_DONE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag_q) else $error("flag not set"); // R9
  AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(done)) else $error("spurious flag"); // R3
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !master_q && pin_edge.lead) |=> !ready_o) else $error("ready held"); // R8
  AST_TRIG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_ctrl && !done) |=> busy_q) else $error("busy write took effect"); // R11
endmodule

// File: tb/sio_shift_port_test.sv
module sio_shift_port_test;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [3:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [3:0] rd_data_o;
  logic       sclk_i = 1'b1;
  logic       sclk_o, sclk_oe_o, sdo_o, ready_o, irq_o;
  logic       sdi_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  sio_shift_port #(.CLK_DIV(CLK_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .ready_o(ready_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  bit         mst_mode = 1'b0;
  bit         mst_act  = 1'b0;
  logic [7:0] mst_rx   = '0;
  int         mon_bits = 0;
  logic [7:0] mon_byte = '0;

  // remote device for master mode: launch-edge-to-trail holds the inverse
  initial begin : remote_slave
    logic prev;
    int   idx;
    prev = 1'b1; idx = 0;
    forever begin
      @(negedge clk);
      if (!mst_act) begin
        idx = 0; sdi_i = mst_mode ? mst_rx[0] : sdi_i;
      end else if (sclk_o != prev) begin
        if (sclk_o == 1'b0) sdi_i = ~mst_rx[idx];
        else begin
          idx++;
          if (idx < 8) sdi_i = mst_rx[idx];
        end
      end
      prev = sclk_o;
    end
  end

  // monitor: collects sdo at trailing edges, checks half period in master mode
  initial begin : monitor
    logic prev, line;
    int   since;
    logic [7:0] e;
    prev = 1'b1; since = 0;
    forever begin
      @(negedge clk);
      line = mst_mode ? sclk_o : sclk_i;
      since++;
      if (line != prev) begin
        if (line == 1'b1) begin
          if (mst_mode) check(since == HALF, "R7 half period", since, HALF);
          mon_byte = {sdo_o, mon_byte[7:1]};
          mon_bits++;
          if (mon_bits == 8) begin
            mon_bits = 0;
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected byte", mon_byte, 0);
            else begin
              e = exp_q.pop_front();
              check(mon_byte == e, "R4 tx byte lsb first", mon_byte, e);
            end
          end
        end
        since = 0;
      end
      prev = line;
    end
  end

  task automatic wait_done(input string req);
    logic [3:0] d;
    bit got;
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(2'd3, d);
      if (d[0]) begin got = 1'b1; break; end
    end
    check(got, req, got, 1);
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] rx, input bit lead_s,
                            input bit stray_trig);
    logic [3:0] lo, hi, c;
    logic [7:0] exp_rx;
    mst_mode = 1'b1; mst_rx = rx;
    reg_wr(2'd0, tx[3:0]);
    reg_wr(2'd1, tx[7:4]);
    exp_q.push_back(tx);
    @(negedge clk); sdi_i = rx[0]; mst_act = 1'b1;
    reg_wr(2'd2, {1'b0, lead_s, 1'b1, 1'b1});
    reg_rd(2'd2, c);
    check(c[0] == 1'b1, "R3 busy during transfer", c[0], 1);
    check(sclk_oe_o == 1'b1, "R7 clock enabled in master", sclk_oe_o, 1);
    if (stray_trig) begin
      repeat (6) @(negedge clk);
      reg_wr(2'd2, 4'b0001);               // R11 stray start while busy
    end
    wait_done("R3 done flag after transfer");
    mst_act = 1'b0;
    reg_rd(2'd2, c);
    check(c[0] == 1'b0, "R3 busy cleared", c[0], 0);
    reg_rd(2'd0, lo);
    reg_rd(2'd1, hi);
    exp_rx = lead_s ? rx : ~rx;
    check({hi, lo} == exp_rx, lead_s ? "R6 R5 launch-edge rx" : "R6 R5 trail-edge rx",
          {hi, lo}, exp_rx);
    repeat (20) @(negedge clk);
    check(sclk_o == 1'b1, "R7 clock idle after transfer", sclk_o, 1);
    check(mon_bits == 0 && exp_q.size() == 0, "R11 exactly 8 cycles", mon_bits, 0);
    reg_wr(2'd3, 4'b0001);
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx, input bit lead_s);
    logic [3:0] lo, hi;
    logic [7:0] exp_rx;
    mst_mode = 1'b0;
    reg_wr(2'd0, tx[3:0]);
    reg_wr(2'd1, tx[7:4]);
    exp_q.push_back(tx);
    reg_wr(2'd2, {1'b0, lead_s, 1'b0, 1'b1});
    @(negedge clk);
    check(ready_o == 1'b1, "R8 ready after start", ready_o, 1);
    check(sclk_oe_o == 1'b0, "R8 clock not driven in slave", sclk_oe_o, 0);
    for (int k = 0; k < 8; k++) begin
      sdi_i = rx[k];
      sclk_i = 1'b0;
      repeat (5) @(negedge clk);
      if (k == 0) check(ready_o == 1'b0, "R8 ready drops at first edge", ready_o, 0);
      sdi_i = ~rx[k];
      repeat (3) @(negedge clk);
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
    end
    wait_done("R3 R8 slave done");
    reg_rd(2'd0, lo);
    reg_rd(2'd1, hi);
    exp_rx = lead_s ? rx : ~rx;
    check({hi, lo} == exp_rx, "R5 R6 slave rx", {hi, lo}, exp_rx);
    check(exp_q.size() == 0, "R4 slave tx seen", exp_q.size(), 0);
    reg_wr(2'd3, 4'b0001);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : driver
    logic [3:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], d);
      check(d == 4'h0, "R1 register reset", d, 0);
    end
    check(sclk_o == 1'b1 && ready_o == 1'b0 && irq_o == 1'b0, "R1 outputs at reset",
          {sclk_o, ready_o, irq_o}, 3'b100);

    reg_wr(2'd0, 4'h5);
    reg_wr(2'd1, 4'hA);
    reg_rd(2'd0, d); check(d == 4'h5, "R2 low nibble", d, 5);
    reg_rd(2'd1, d); check(d == 4'hA, "R2 high nibble", d, 4'hA);

    run_master(8'hA5, 8'h3C, 1'b0, 1'b0);
    run_master(8'h01, 8'hC9, 1'b1, 1'b0);
    run_master(8'h7E, 8'h80, 1'b0, 1'b1);

    // R9: flag sets with interrupt disabled, irq follows enable
    reg_wr(2'd3, 4'b0000);
    run_slave(8'h96, 8'h5A, 1'b1);
    run_slave(8'hF0, 8'h0F, 1'b0);
    mst_mode = 1'b1;
    reg_wr(2'd0, 4'h3); reg_wr(2'd1, 4'hC);
    exp_q.push_back(8'hC3);
    mst_rx = 8'h00; mst_act = 1'b1;
    reg_wr(2'd2, 4'b0011);
    wait_done("R9 flag with irq disabled");
    mst_act = 1'b0;
    check(irq_o == 1'b0, "R9 irq masked", irq_o, 0);
    reg_wr(2'd3, 4'b0010);
    @(negedge clk);
    check(irq_o == 1'b1, "R9 irq enabled", irq_o, 1);
    reg_rd(2'd3, d);
    check(d[0] == 1'b1, "R10 write 0 keeps flag", d[0], 1);
    reg_wr(2'd3, 4'b0011);
    reg_rd(2'd3, d);
    check(d[0] == 1'b0 && irq_o == 1'b0, "R10 write 1 clears flag", d[0], 0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule